// File: doc/BRIEF.md
# Bus Cycle Breakpoint Comparator

This debug unit watches every bus cycle of a processor and flags a breakpoint hit when the cycle matches programmed conditions. Software programs four items through a small register port:

- an address compare value and an address mask, each split over two 16-bit words;
- a 2-bit control compare word;
- a 2-bit control mask word.

Each bus cycle presents its address, a read/write flag, an instruction/data flag and a valid strobe. The hit is registered, so it appears one clock after the matching cycle.

A 2-bit mode input picks how the address and control comparisons combine.

- **Program-break mode:** only the address comparison counts.
- **Single-breakpoint mode:** address and control must both match. The unit drives the shared break line itself.
- **Multiple-breakpoint mode:** the shared break line is released and becomes an input. It is ANDed with the local address and control matches, so several units can be chained.

The break line is brought out as separate output, output-enable and input pins, so the pad or the chip top can build the bidirectional wire.

Register index map on `reg_idx`:

| Index | Register |
|-------|----------|
| 0 | Address compare, low word |
| 1 | Address compare, high word |
| 2 | Address mask, low word |
| 3 | Address mask, high word |
| 4 | Control compare |
| 5 | Control mask |
| 6, 7 | Unused |

Top module: `bus_bkpt_unit`

## Requirements
- R1: After a synchronous active-low reset, every register index reads 0x0000 and `hit` and `brk_out` are low.
- R2: Only implemented bits are stored. Control compare and control mask keep bits 1:0 and read bits 15:2 as zero. Address words read zero above bit ADDR_W-1. Indices 6 and 7 read zero and ignore writes.
- R3: The address matches when every address bit whose mask bit is 0 equals the compare bit. A mask bit of 1 excludes that address bit from the comparison.
- R4: Control compare bit 1 selects the access direction (1 = read cycle, 0 = write cycle). Bit 0 selects the cycle type (1 = instruction cycle, 0 = data cycle). They are compared against `bus_read` and `bus_instr`.
- R5: A control mask bit of 1 (bit 1 for direction, bit 0 for type) makes that control bit always count as matching.
- R6: When `brk_mode` = 1 (single), `brk_out_en` is high. `brk_out` and `hit` are high in the clock after a valid cycle whose address and control both match.
- R7: When `brk_mode` = 2 (multiple), `brk_out_en` and `brk_out` stay low. `hit` is high in the clock after a valid cycle only if `brk_in`, the address match and the control match are all high.
- R8: When `brk_mode` = 0 (program break), the control registers have no effect. `hit` follows the address match alone, and `brk_out_en` is low.
- R9: A cycle with `bus_valid` low never produces a hit, whatever its address and flags.
- R10: `hit` is high for exactly one clock per matching valid cycle. Back-to-back matching cycles give consecutive high clocks.
- R11: `brk_mode` = 3 disables the unit: no hit, and the break line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational, from `reg_idx`) |
| bus_valid | input | 1 | Bus cycle valid strobe |
| bus_addr | input | ADDR_W | Bus cycle address |
| bus_read | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_instr | input | 1 | 1 = instruction cycle, 0 = data cycle |
| brk_mode | input | 2 | 0 program break, 1 single, 2 multiple, 3 off |
| brk_in | input | 1 | Break line as seen at the pad |
| brk_out | output | 1 | Break line drive value |
| brk_out_en | output | 1 | Break line drive enable |
| hit | output | 1 | Registered internal breakpoint match |

## Verification
Address patterns place the compare value against addresses that differ only in masked low bits and addresses that differ in an unmasked bit. This separates a masked compare from an exact or inverted one.

All four combinations of direction and type are sent against several compare and mask settings. This tells a swapped or inverted control bit apart from a broken mask.

The same matching cycle is replayed in each mode, with the break input high and low. This shows which qualifiers each mode honours and who drives the line.

Back-to-back and strobe-low cycles confirm the one-clock-per-cycle timing.

// File: rtl/bkpt_pkg.sv
// Shared definitions for the bus cycle breakpoint comparator.
// Assumes register words of 16 bits and two control attributes per cycle.
package bkpt_pkg;

    typedef enum logic [1:0] {
        BK_PROG   = 2'd0,
        BK_SINGLE = 2'd1,
        BK_MULTI  = 2'd2,
        BK_OFF    = 2'd3
    } bk_mode_e;

    localparam int CTRL_BITS = 2;
    localparam int CB_INSTR  = 0;  // cycle type attribute position
    localparam int CB_READ   = 1;  // access direction attribute position

    localparam logic [2:0] RI_ACMP_LO = 3'd0;
    localparam logic [2:0] RI_ACMP_HI = 3'd1;
    localparam logic [2:0] RI_AMSK_LO = 3'd2;
    localparam logic [2:0] RI_AMSK_HI = 3'd3;
    localparam logic [2:0] RI_CCMP    = 3'd4;
    localparam logic [2:0] RI_CMSK    = 3'd5;

endpackage

// File: rtl/bkpt_regs.sv
// Register file of the breakpoint comparator.
// Holds the address compare/mask values (split over two words) and the
// 2-bit control compare/mask words. Unimplemented bits read as zero.
// Assumes DATA_W < ADDR_W <= 2*DATA_W.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           idx,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [ADDR_W-1:0]    acmp,
    output logic [ADDR_W-1:0]    amask,
    output logic [CTRL_BITS-1:0] ccmp,
    output logic [CTRL_BITS-1:0] cmask
);

    localparam int SPAN = 2 * DATA_W;

    logic [ADDR_W-1:0]    acmp_q;
    logic [ADDR_W-1:0]    amask_q;
    logic [CTRL_BITS-1:0] ccmp_q;
    logic [CTRL_BITS-1:0] cmask_q;
    logic [SPAN-1:0]      acmp_pad;
    logic [SPAN-1:0]      amask_pad;

    // Per address bit storage: each bit belongs to the low or high word.
    for (genvar gb = 0; gb < ADDR_W; gb++) begin : g_abit
        localparam logic [2:0] CMP_IDX = 3'(32'(RI_ACMP_LO) + gb / DATA_W);
        localparam logic [2:0] MSK_IDX = 3'(32'(RI_AMSK_LO) + gb / DATA_W);

        // Store one compare bit and one mask bit when its word is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acmp_q[gb]  <= 1'b0;
                amask_q[gb] <= 1'b0;
            end else if (wr_en) begin
                if (idx == CMP_IDX) acmp_q[gb]  <= wdata[gb % DATA_W];
                if (idx == MSK_IDX) amask_q[gb] <= wdata[gb % DATA_W];
            end
        end
    end

    // Store the two control words, keeping only their low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccmp_q  <= '0;
            cmask_q <= '0;
        end else if (wr_en) begin
            if (idx == RI_CCMP) ccmp_q  <= wdata[CTRL_BITS-1:0];
            if (idx == RI_CMSK) cmask_q <= wdata[CTRL_BITS-1:0];
        end
    end

    assign acmp_pad  = SPAN'(acmp_q);
    assign amask_pad = SPAN'(amask_q);

    // Read multiplexer with zero fill for unused bits and indices.
    always_comb begin
        rdata = '0;
        unique case (idx)
            RI_ACMP_LO: rdata = acmp_pad[DATA_W-1:0];
            RI_ACMP_HI: rdata = acmp_pad[SPAN-1:DATA_W];
            RI_AMSK_LO: rdata = amask_pad[DATA_W-1:0];
            RI_AMSK_HI: rdata = amask_pad[SPAN-1:DATA_W];
            RI_CCMP:    rdata = DATA_W'(ccmp_q);
            RI_CMSK:    rdata = DATA_W'(cmask_q);
            default:    rdata = '0;
        endcase
    end

    assign acmp  = acmp_q;
    assign amask = amask_q;
    assign ccmp  = ccmp_q;
    assign cmask = cmask_q;

    // R2
    ctrl_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == RI_CCMP) |=> (ccmp == $past(wdata[CTRL_BITS-1:0])));

endmodule

// File: rtl/bkpt_addr_cmp.sv
// Masked address comparator.
// A mask bit of 1 removes that address bit from the equality test.
// Purely combinational; assumes inputs are stable within the cycle.
module bkpt_addr_cmp #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] cmp,
    input  logic [ADDR_W-1:0] mask,
    output logic              match
);

    logic [ADDR_W-1:0] diff;

    // Bits that differ and are not excluded by the mask.
    always_comb begin
        diff  = (addr ^ cmp) & ~mask;
        match = (diff == '0);
    end

endmodule

// File: rtl/bkpt_ctrl_cmp.sv
// Control attribute comparator for direction and cycle type.
// Each attribute matches when it equals its compare bit or its mask bit
// is set; the overall match is the AND over all attributes.
module bkpt_ctrl_cmp
    import bkpt_pkg::*;
(
    input  logic [CTRL_BITS-1:0] attr,
    input  logic [CTRL_BITS-1:0] cmp,
    input  logic [CTRL_BITS-1:0] mask,
    output logic                 match
);

    logic [CTRL_BITS-1:0] bit_ok;

    for (genvar gi = 0; gi < CTRL_BITS; gi++) begin : g_cbit
        // One attribute: masked out or equal to the programmed value.
        assign bit_ok[gi] = mask[gi] | (cmp[gi] == attr[gi]);
    end

    assign match = &bit_ok;

endmodule

// File: rtl/bus_bkpt_unit.sv
// Bus cycle breakpoint comparator top.
// Combines the address and control matches according to the mode, gates
// with the cycle strobe and registers the result for one clock. The break
// line is split into drive value, drive enable and pad input.
// Assumes bus inputs are synchronous to clk.
module bus_bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_read,
    input  logic              bus_instr,
    input  logic [1:0]        brk_mode,
    input  logic              brk_in,
    output logic              brk_out,
    output logic              brk_out_en,
    output logic              hit
);

    logic [ADDR_W-1:0]    acmp;
    logic [ADDR_W-1:0]    amask;
    logic [CTRL_BITS-1:0] ccmp;
    logic [CTRL_BITS-1:0] cmask;
    logic [CTRL_BITS-1:0] attr;
    logic                 addr_hit;
    logic                 ctrl_hit;
    logic                 local_hit;
    logic                 match_now;
    logic                 hit_q;
    logic                 brk_q;
    bk_mode_e             mode;

    assign mode           = bk_mode_e'(brk_mode);
    assign attr[CB_READ]  = bus_read;
    assign attr[CB_INSTR] = bus_instr;

    bkpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .acmp  (acmp),
        .amask (amask),
        .ccmp  (ccmp),
        .cmask (cmask)
    );

    bkpt_addr_cmp #(.ADDR_W(ADDR_W)) i_addr_cmp (
        .addr  (bus_addr),
        .cmp   (acmp),
        .mask  (amask),
        .match (addr_hit)
    );

    bkpt_ctrl_cmp i_ctrl_cmp (
        .attr  (attr),
        .cmp   (ccmp),
        .mask  (cmask),
        .match (ctrl_hit)
    );

    // Mode-dependent combination of the comparator results.
    always_comb begin
        unique case (mode)
            BK_PROG:   local_hit = addr_hit;
            BK_SINGLE: local_hit = addr_hit & ctrl_hit;
            BK_MULTI:  local_hit = addr_hit & ctrl_hit & brk_in;
            default:   local_hit = 1'b0;
        endcase
        match_now = bus_valid & local_hit;
    end

    // Register the hit and the break line drive for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            hit_q <= match_now;
            brk_q <= match_now && (mode == BK_SINGLE);
        end
    end

    assign hit        = hit_q;
    assign brk_out    = brk_q;
    assign brk_out_en = (mode == BK_SINGLE);

    // R6
    single_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && mode == BK_SINGLE && addr_hit && ctrl_hit) |=> (brk_out && hit));

    // R7
    multi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BK_MULTI && !brk_in) |=> !hit);

    // R8
    prog_addr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && mode == BK_PROG && addr_hit) |=> hit);

    // R9
    idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !hit);

    // R11
    off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BK_OFF) |=> !hit);

endmodule

// File: tb/test_bus_bkpt_unit.sv
module test_bus_bkpt_unit;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [2:0]        reg_idx = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              bus_valid = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_read = 1'b0;
    logic              bus_instr = 1'b0;
    logic [1:0]        brk_mode = 2'd1;
    logic              brk_in = 1'b0;
    logic              brk_out;
    logic              brk_out_en;
    logic              hit;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bus_bkpt_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus_bkpt_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_read(bus_read), .bus_instr(bus_instr),
        .brk_mode(brk_mode), .brk_in(brk_in), .brk_out(brk_out),
        .brk_out_en(brk_out_en), .hit(hit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic program_unit(input logic [ADDR_W-1:0] ac, input logic [ADDR_W-1:0] am,
                                input logic [1:0] cc, input logic [1:0] cm);
        wr(3'd0, ac[15:0]); wr(3'd1, 16'(ac[ADDR_W-1:16]));
        wr(3'd2, am[15:0]); wr(3'd3, 16'(am[ADDR_W-1:16]));
        wr(3'd4, 16'(cc)); wr(3'd5, 16'(cm));
    endtask

    // One bus cycle; returns hit and brk_out seen in the following clock.
    task automatic cyc(input logic v, input logic [ADDR_W-1:0] a, input logic r,
                       input logic ins, output logic h, output logic b);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_read = r; bus_instr = ins;
        @(negedge clk);
        bus_valid = 1'b0;
        h = hit; b = brk_out;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), d);
            check("R1 reg reset", 32'(d), 32'h0);
        end
        check("R1 hit reset", 32'(hit), 0);
        check("R1 brk_out reset", 32'(brk_out), 0);
    endtask

    task automatic t_reserved();
        logic [DATA_W-1:0] d;
        wr(3'd4, 16'hFFFF); rd(3'd4, d); check("R2 ctrl cmp bits", 32'(d), 32'h3);
        wr(3'd5, 16'hFFFE); rd(3'd5, d); check("R2 ctrl mask bits", 32'(d), 32'h2);
        wr(3'd1, 16'hFFFF); rd(3'd1, d); check("R2 addr hi bits", 32'(d), 32'hFF);
        wr(3'd6, 16'hFFFF); rd(3'd6, d); check("R2 idx6 reads zero", 32'(d), 32'h0);
        rd(3'd0, d); check("R2 idx6 write no effect", 32'(d), 32'h0);
    endtask

    task automatic t_addr_mask();
        logic h, b;
        brk_mode = 2'd1;
        program_unit(24'h123450, 24'h00000F, 2'b00, 2'b11);
        cyc(1, 24'h12345A, 0, 0, h, b); check("R3 masked bits differ", 32'(h), 1);
        cyc(1, 24'h12346A, 0, 0, h, b); check("R3 unmasked bit differs", 32'(h), 0);
        cyc(1, 24'h923450, 0, 0, h, b); check("R3 top bit differs", 32'(h), 0);
    endtask

    task automatic t_ctrl_cmp();
        logic h, b;
        program_unit(24'hABCDE0, 24'h0, 2'b10, 2'b00);
        cyc(1, 24'hABCDE0, 1, 0, h, b); check("R4 read data", 32'(h), 1);
        cyc(1, 24'hABCDE0, 0, 0, h, b); check("R4 write data rejected", 32'(h), 0);
        cyc(1, 24'hABCDE0, 1, 1, h, b); check("R4 read instr rejected", 32'(h), 0);
        wr(3'd4, 16'h0001);
        cyc(1, 24'hABCDE0, 0, 1, h, b); check("R4 write instr", 32'(h), 1);
        cyc(1, 24'hABCDE0, 1, 1, h, b); check("R4 read instr vs write sel", 32'(h), 0);
    endtask

    task automatic t_ctrl_mask();
        logic h, b;
        wr(3'd4, 16'h0001); wr(3'd5, 16'h0002);
        cyc(1, 24'hABCDE0, 0, 1, h, b); check("R5 dir masked write", 32'(h), 1);
        cyc(1, 24'hABCDE0, 1, 1, h, b); check("R5 dir masked read", 32'(h), 1);
        cyc(1, 24'hABCDE0, 1, 0, h, b); check("R5 type still compared", 32'(h), 0);
        wr(3'd5, 16'h0001);
        cyc(1, 24'hABCDE0, 0, 0, h, b); check("R5 type masked", 32'(h), 1);
    endtask

    task automatic t_single();
        logic h, b;
        brk_mode = 2'd1;
        wr(3'd4, 16'h0002); wr(3'd5, 16'h0000);
        #1 check("R6 drive enable", 32'(brk_out_en), 1);
        cyc(1, 24'hABCDE0, 1, 0, h, b);
        check("R6 brk_out on match", 32'(b), 1); check("R6 hit on match", 32'(h), 1);
        cyc(1, 24'hABCDE1, 1, 0, h, b); check("R6 brk_out no match", 32'(b), 0);
    endtask

    task automatic t_multi();
        logic h, b;
        brk_mode = 2'd2; brk_in = 1'b1;
        #1 check("R7 drive released", 32'(brk_out_en), 0);
        cyc(1, 24'hABCDE0, 1, 0, h, b);
        check("R7 hit with line high", 32'(h), 1); check("R7 brk_out low", 32'(b), 0);
        brk_in = 1'b0;
        cyc(1, 24'hABCDE0, 1, 0, h, b); check("R7 line low blocks", 32'(h), 0);
        brk_in = 1'b1;
        cyc(1, 24'hABCDE0, 0, 0, h, b); check("R7 ctrl mismatch blocks", 32'(h), 0);
        brk_in = 1'b0;
    endtask

    task automatic t_program();
        logic h, b;
        brk_mode = 2'd0;
        #1 check("R8 drive released", 32'(brk_out_en), 0);
        cyc(1, 24'hABCDE0, 0, 1, h, b);
        check("R8 ctrl ignored", 32'(h), 1); check("R8 brk_out low", 32'(b), 0);
        cyc(1, 24'hABCDE8, 1, 0, h, b); check("R8 addr mismatch", 32'(h), 0);
    endtask

    task automatic t_valid_low();
        logic h, b;
        brk_mode = 2'd1;
        cyc(0, 24'hABCDE0, 1, 0, h, b);
        check("R9 strobe low hit", 32'(h), 0); check("R9 strobe low brk", 32'(b), 0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        bus_valid = 1; bus_addr = 24'hABCDE0; bus_read = 1; bus_instr = 0;
        @(negedge clk); check("R10 first cycle", 32'(hit), 1);
        @(negedge clk); check("R10 second cycle", 32'(hit), 1);
        bus_valid = 0;
        @(negedge clk); check("R10 drops after", 32'(hit), 0);
    endtask

    task automatic t_off();
        logic h, b;
        brk_mode = 2'd3; brk_in = 1'b1;
        #1 check("R11 line released", 32'(brk_out_en), 0);
        cyc(1, 24'hABCDE0, 1, 0, h, b); check("R11 no hit", 32'(h), 0);
        brk_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_addr_mask();
        t_ctrl_cmp();
        t_ctrl_mask();
        t_single();
        t_multi();
        t_program();
        t_valid_low();
        t_back_to_back();
        t_off();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule